// File: doc/BRIEF.md
# Peripheral Interrupt and Clock Aggregator

This block sits between the on-chip peripherals and the interrupt controller of a chip. It gathers raw interrupt lines from ordinary peripherals, from a group of always-running system peripherals, from three timer channels and from three external pins. It registers them into one numbered interrupt source vector. Seven system lines share one source. The three timer channels share another. The fast-interrupt pin and two general interrupt pins each get a source of their own.

The same block owns the per-identifier clock enables. A small register port gives three accesses: a write-1-to-set access, a write-1-to-clear access and a read-only status view. Fixed rules decide which bits can really change. The system source is always clocked, and the external-pin identifiers have no clock at all. A single enable drives all three timer-channel clocks together. Interrupt forwarding ignores the clock state, so a gated peripheral whose line is still raised keeps its source asserted.

Top module: `pirq_clk_hub`

## Requirements
- R1: Source 1 of `irq_src` is the OR of all seven `sys_irq` lines.
- R2: Source 19 of `irq_src` is the OR of all three `tmr_irq` lines.
- R3: `ext_fiq` drives source 0. `ext_irq[0]` drives source 30 and `ext_irq[1]` drives source 31. Every other source n follows `dev_irq[n]`. The `dev_irq` bits 0, 1, 19, 30 and 31 have no effect on `irq_src`.
- R4: `irq_src` is registered. It is all zero in reset and shows a changed input after the next rising clock edge, not before.
- R5: A write with `reg_sel` = 0 (set) turns on the enable of every gateable identifier whose `reg_wdata` bit is 1. Other bits keep their value. The change is visible after the write's clock edge.
- R6: A write with `reg_sel` = 1 (clear) turns off the enable of every gateable identifier whose `reg_wdata` bit is 1. Other bits keep their value.
- R7: With `reg_sel` = 2, `reg_rdata` shows the current enable vector. For `reg_sel` 0, 1 and 3 it reads zero. Writes with `reg_sel` 2 or 3 leave the enables unchanged.
- R8: After reset, `clk_en` equals 0x00000002: only identifier 1 is enabled.
- R9: Bit 1 of `clk_en` stays 1. A clear write that includes bit 1 has no effect on it.
- R10: Bits 0, 30 and 31 of `clk_en` stay 0. Set writes that include them have no effect.
- R11: All three bits of `tmr_clk_en` equal bit 19 of `clk_en`, so one clear of bit 19 stops all three timer clocks.
- R12: The interrupt path does not depend on `clk_en`. A source whose clock is off still forwards its line.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Ungated clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sys_irq | input | 7 | System peripheral interrupt lines |
| tmr_irq | input | 3 | Timer channel interrupt lines |
| ext_fiq | input | 1 | Fast interrupt pin |
| ext_irq | input | 2 | General interrupt pins |
| dev_irq | input | 32 | Ordinary peripheral lines, indexed by identifier |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 2 | Access select: 0 set, 1 clear, 2 status, 3 none |
| reg_wdata | input | 32 | Write data, one bit per identifier |
| reg_rdata | output | 32 | Read data |
| irq_src | output | 32 | Registered interrupt source vector |
| clk_en | output | 32 | Clock enable per identifier |
| tmr_clk_en | output | 3 | Clock enables of the three timer channels |

## Verification
The bench drives each system line and each timer line alone. A design that ORed only some of them, or put a merged line on the wrong source, would leave source 1 or 19 low for that line. It drives every `dev_irq` bit high at once, which exposes a mapper that leaks a shared or external bit through its raw lane. It writes all-ones to set and clear, so a design that let the always-on bit drop, or let the external-pin bits rise, shows the wrong `clk_en`. It also samples `irq_src` before and after the clock edge to catch a combinational bypass, and it forwards an interrupt with every clock off to catch a design that masks lines by their clock enable.

// File: rtl/pirq_pkg.sv
package pirq_pkg;

   typedef enum logic [1:0] {
      SEL_SET  = 2'd0,
      SEL_CLR  = 2'd1,
      SEL_STAT = 2'd2,
      SEL_NONE = 2'd3
   } reg_sel_e;

   typedef enum logic [1:0] {
      ROLE_DEV = 2'd0,
      ROLE_SYS = 2'd1,
      ROLE_TMR = 2'd2,
      ROLE_EXT = 2'd3
   } id_role_e;

   localparam int MAX_IDS = 32;

   function automatic id_role_e role_of(input int id, input int sys_id, input int tmr_id,
                                        input int fiq_id, input int irq_base, input int n_ext);
      if (id == sys_id) return ROLE_SYS;
      if (id == tmr_id) return ROLE_TMR;
      if (id == fiq_id) return ROLE_EXT;
      if (id >= irq_base && id < irq_base + n_ext) return ROLE_EXT;
      return ROLE_DEV;
   endfunction

   // Builds a bit mask of all identifiers whose role equals want.
   function automatic logic [MAX_IDS-1:0] role_mask(input id_role_e want, input int n_ids,
                                                    input int sys_id, input int tmr_id,
                                                    input int fiq_id, input int irq_base,
                                                    input int n_ext);
      logic [MAX_IDS-1:0] m;
      m = '0;
      for (int k = 0; k < n_ids; k++) begin
         if (role_of(k, sys_id, tmr_id, fiq_id, irq_base, n_ext) == want) m[k] = 1'b1;
      end
      return m;
   endfunction

endpackage

// File: rtl/pirq_src_map.sv
module pirq_src_map
   import pirq_pkg::*;
#(
   parameter int NUM_IDS     = 32,
   parameter int NUM_SYS     = 7,
   parameter int NUM_TMR     = 3,
   parameter int NUM_EXT_IRQ = 2,
   parameter int SYS_ID      = 1,
   parameter int TMR_ID      = 19,
   parameter int FIQ_ID      = 0,
   parameter int IRQ_BASE_ID = 30
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic [NUM_SYS-1:0]     sys_irq,
   input  logic [NUM_TMR-1:0]     tmr_irq,
   input  logic                   ext_fiq,
   input  logic [NUM_EXT_IRQ-1:0] ext_irq,
   input  logic [NUM_IDS-1:0]     dev_irq,
   output logic [NUM_IDS-1:0]     irq_src
);

   logic [NUM_IDS-1:0] src_nxt;
   logic [NUM_IDS-1:0] dev_unused_bits;
   logic               dev_unused_fold;
   logic               sys_any;
   logic               tmr_any;

   assign sys_any = |sys_irq;
   assign tmr_any = |tmr_irq;

   for (genvar i = 0; i < NUM_IDS; i++) begin : g_lane
      localparam id_role_e LR = role_of(i, SYS_ID, TMR_ID, FIQ_ID, IRQ_BASE_ID, NUM_EXT_IRQ);
      if (LR == ROLE_SYS) begin : g_sys
         assign src_nxt[i]         = sys_any;
         assign dev_unused_bits[i] = dev_irq[i];
      end else if (LR == ROLE_TMR) begin : g_tmr
         assign src_nxt[i]         = tmr_any;
         assign dev_unused_bits[i] = dev_irq[i];
      end else if (i == FIQ_ID) begin : g_fiq
         assign src_nxt[i]         = ext_fiq;
         assign dev_unused_bits[i] = dev_irq[i];
      end else if (LR == ROLE_EXT) begin : g_ext
         assign src_nxt[i]         = ext_irq[i-IRQ_BASE_ID];
         assign dev_unused_bits[i] = dev_irq[i];
      end else begin : g_dev
         assign src_nxt[i]         = dev_irq[i];
         assign dev_unused_bits[i] = 1'b0;
      end
   end

   // Raw lanes that a shared or pin source replaces are dropped on purpose.
   assign dev_unused_fold = ^dev_unused_bits;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) irq_src <= '0;
      else        irq_src <= src_nxt;
   end

   p_sys_merge_r1: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> irq_src[SYS_ID] == $past(|sys_irq));

   p_tmr_merge_r2: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> irq_src[TMR_ID] == $past(|tmr_irq));

   p_fiq_route_r3: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> irq_src[FIQ_ID] == $past(ext_fiq));

   p_irq_route_r3: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> irq_src[IRQ_BASE_ID +: NUM_EXT_IRQ] == $past(ext_irq));

endmodule

// File: rtl/pirq_clk_ctrl.sv
module pirq_clk_ctrl
   import pirq_pkg::*;
#(
   parameter int                 NUM_IDS   = 32,
   parameter logic [NUM_IDS-1:0] GATE_MASK = '0,
   parameter logic [NUM_IDS-1:0] ON_MASK   = '0
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               wr,
   input  logic [1:0]         sel,
   input  logic [NUM_IDS-1:0] wdata,
   output logic [NUM_IDS-1:0] en_q
);

   logic [NUM_IDS-1:0] en_d;
   logic [NUM_IDS-1:0] hit;
   reg_sel_e           sel_e;

   assign sel_e = reg_sel_e'(sel);
   assign hit   = wdata & GATE_MASK;

   always_comb begin
      en_d = en_q;
      if (wr) begin
         unique case (sel_e)
            SEL_SET: en_d = en_q | hit;
            SEL_CLR: en_d = en_q & ~hit;
            default: en_d = en_q;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) en_q <= ON_MASK;
      else        en_q <= (en_d & GATE_MASK) | ON_MASK;
   end

   p_set_bits_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (wr && sel == SEL_SET) |=> ((en_q & $past(wdata) & GATE_MASK) == ($past(wdata) & GATE_MASK)));

   p_clr_bits_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (wr && sel == SEL_CLR) |=> ((en_q & $past(wdata) & GATE_MASK) == '0));

   p_idle_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (!wr || sel == SEL_STAT || sel == SEL_NONE) |=> $stable(en_q));

   p_always_on_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (wr && sel == SEL_CLR) |=> ((en_q & ON_MASK) == ON_MASK));

   p_no_clock_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (wr && sel == SEL_SET) |=> ((en_q & ~(GATE_MASK | ON_MASK)) == '0));

endmodule

// File: rtl/pirq_clk_hub.sv
module pirq_clk_hub
   import pirq_pkg::*;
#(
   parameter int NUM_IDS     = 32,
   parameter int NUM_SYS     = 7,
   parameter int NUM_TMR     = 3,
   parameter int NUM_EXT_IRQ = 2,
   parameter int SYS_ID      = 1,
   parameter int TMR_ID      = 19,
   parameter int FIQ_ID      = 0,
   parameter int IRQ_BASE_ID = 30
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic [NUM_SYS-1:0]     sys_irq,
   input  logic [NUM_TMR-1:0]     tmr_irq,
   input  logic                   ext_fiq,
   input  logic [NUM_EXT_IRQ-1:0] ext_irq,
   input  logic [NUM_IDS-1:0]     dev_irq,
   input  logic                   reg_wr,
   input  logic [1:0]             reg_sel,
   input  logic [NUM_IDS-1:0]     reg_wdata,
   output logic [NUM_IDS-1:0]     reg_rdata,
   output logic [NUM_IDS-1:0]     irq_src,
   output logic [NUM_IDS-1:0]     clk_en,
   output logic [NUM_TMR-1:0]     tmr_clk_en
);

   localparam logic [MAX_IDS-1:0] SYS_M =
      role_mask(ROLE_SYS, NUM_IDS, SYS_ID, TMR_ID, FIQ_ID, IRQ_BASE_ID, NUM_EXT_IRQ);
   localparam logic [MAX_IDS-1:0] EXT_M =
      role_mask(ROLE_EXT, NUM_IDS, SYS_ID, TMR_ID, FIQ_ID, IRQ_BASE_ID, NUM_EXT_IRQ);
   localparam logic [NUM_IDS-1:0] ON_MASK   = SYS_M[NUM_IDS-1:0];
   localparam logic [NUM_IDS-1:0] GATE_MASK = ~(SYS_M[NUM_IDS-1:0] | EXT_M[NUM_IDS-1:0]);

   if (NUM_IDS < 4 || NUM_IDS > MAX_IDS) begin : g_bad_ids
      $error("pirq_clk_hub: NUM_IDS out of range");
   end
   if (NUM_SYS < 1 || NUM_TMR < 1 || NUM_EXT_IRQ < 0) begin : g_bad_groups
      $error("pirq_clk_hub: group sizes must be positive");
   end
   if (SYS_ID == TMR_ID || SYS_ID == FIQ_ID || TMR_ID == FIQ_ID) begin : g_bad_fixed
      $error("pirq_clk_hub: fixed identifiers collide");
   end
   if (IRQ_BASE_ID + NUM_EXT_IRQ > NUM_IDS || SYS_ID >= NUM_IDS || TMR_ID >= NUM_IDS
       || FIQ_ID >= NUM_IDS) begin : g_bad_range
      $error("pirq_clk_hub: identifier beyond NUM_IDS");
   end
   if ((SYS_ID >= IRQ_BASE_ID && SYS_ID < IRQ_BASE_ID + NUM_EXT_IRQ)
       || (TMR_ID >= IRQ_BASE_ID && TMR_ID < IRQ_BASE_ID + NUM_EXT_IRQ)
       || (FIQ_ID >= IRQ_BASE_ID && FIQ_ID < IRQ_BASE_ID + NUM_EXT_IRQ)) begin : g_bad_ext
      $error("pirq_clk_hub: pin identifiers overlap a fixed identifier");
   end

   pirq_src_map #(
      .NUM_IDS     (NUM_IDS),
      .NUM_SYS     (NUM_SYS),
      .NUM_TMR     (NUM_TMR),
      .NUM_EXT_IRQ (NUM_EXT_IRQ),
      .SYS_ID      (SYS_ID),
      .TMR_ID      (TMR_ID),
      .FIQ_ID      (FIQ_ID),
      .IRQ_BASE_ID (IRQ_BASE_ID)
   ) u_map (
      .clk     (clk),
      .rst_n   (rst_n),
      .sys_irq (sys_irq),
      .tmr_irq (tmr_irq),
      .ext_fiq (ext_fiq),
      .ext_irq (ext_irq),
      .dev_irq (dev_irq),
      .irq_src (irq_src)
   );

   pirq_clk_ctrl #(
      .NUM_IDS   (NUM_IDS),
      .GATE_MASK (GATE_MASK),
      .ON_MASK   (ON_MASK)
   ) u_clk (
      .clk   (clk),
      .rst_n (rst_n),
      .wr    (reg_wr),
      .sel   (reg_sel),
      .wdata (reg_wdata),
      .en_q  (clk_en)
   );

   assign reg_rdata  = (reg_sel == SEL_STAT) ? clk_en : '0;
   assign tmr_clk_en = {NUM_TMR{clk_en[TMR_ID]}};

   p_tmr_stop_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_wr && reg_sel == SEL_CLR && reg_wdata[TMR_ID]) |=> (tmr_clk_en == '0));

   p_tmr_start_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_wr && reg_sel == SEL_SET && reg_wdata[TMR_ID]) |=> (tmr_clk_en == '1));

   p_fwd_gated_r12: assert property (@(posedge clk) disable iff (!rst_n)
      (!clk_en[TMR_ID] && tmr_irq != '0) |=> irq_src[TMR_ID]);

endmodule

// File: tb/sim_pirq_clk_hub.sv
module sim_pirq_clk_hub;

   localparam int CLK_PERIOD = 10;
   localparam logic [31:0] GATE = 32'h3FFF_FFFC;
   localparam logic [31:0] ON   = 32'h0000_0002;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [6:0]  sys_irq = '0;
   logic [2:0]  tmr_irq = '0;
   logic        ext_fiq = 1'b0;
   logic [1:0]  ext_irq = '0;
   logic [31:0] dev_irq = '0;
   logic        reg_wr = 1'b0;
   logic [1:0]  reg_sel = 2'd3;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata, irq_src, clk_en;
   logic [2:0]  tmr_clk_en;

   int checks = 0;
   int failures = 0;
   logic [31:0] exp_en = ON;

   always #(CLK_PERIOD/2) clk = ~clk;

   pirq_clk_hub u0 (
      .clk(clk), .rst_n(rst_n), .sys_irq(sys_irq), .tmr_irq(tmr_irq),
      .ext_fiq(ext_fiq), .ext_irq(ext_irq), .dev_irq(dev_irq),
      .reg_wr(reg_wr), .reg_sel(reg_sel), .reg_wdata(reg_wdata),
      .reg_rdata(reg_rdata), .irq_src(irq_src), .clk_en(clk_en), .tmr_clk_en(tmr_clk_en)
   );

   function automatic logic [31:0] model_src();
      logic [31:0] v;
      v = dev_irq & 32'h3FF7_FFFC;
      v[0]  = ext_fiq;
      v[1]  = |sys_irq;
      v[19] = |tmr_irq;
      v[30] = ext_irq[0];
      v[31] = ext_irq[1];
      return v;
   endfunction

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s: actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic tick();
      @(posedge clk);
      #1;
   endtask

   task automatic reg_write(input logic [1:0] sel, input logic [31:0] data);
      reg_sel = sel; reg_wdata = data; reg_wr = 1'b1;
      tick();
      reg_wr = 1'b0; reg_sel = 2'd3; reg_wdata = '0;
   endtask

   task automatic t_reset();
      chk("R4 reset src", irq_src, 32'h0);
      chk("R8 reset clk_en", clk_en, 32'h2);
      reg_sel = 2'd2; #1;
      chk("R8 reset status read", reg_rdata, 32'h2);
      reg_sel = 2'd3;
      chk("R11 reset tmr_clk_en", {29'd0, tmr_clk_en}, 32'h0);
   endtask

   task automatic t_sys_merge();
      for (int k = 0; k < 7; k++) begin
         sys_irq = 7'(1 << k);
         tick();
         chk("R1 system line merge", irq_src, model_src());
      end
      sys_irq = '0; tick();
      chk("R1 system idle", irq_src, 32'h0);
   endtask

   task automatic t_tmr_merge();
      for (int k = 0; k < 3; k++) begin
         tmr_irq = 3'(1 << k);
         tick();
         chk("R2 timer line merge", irq_src, model_src());
      end
      tmr_irq = '0; tick();
   endtask

   task automatic t_ext_route();
      ext_fiq = 1'b1; tick();
      chk("R3 fiq route", irq_src, 32'h0000_0001);
      ext_fiq = 1'b0; ext_irq = 2'b01; tick();
      chk("R3 irq0 route", irq_src, 32'h4000_0000);
      ext_irq = 2'b10; tick();
      chk("R3 irq1 route", irq_src, 32'h8000_0000);
      ext_irq = 2'b00; dev_irq = 32'hFFFF_FFFF; tick();
      chk("R3 raw lanes of shared ids ignored", irq_src, 32'h3FF7_FFFC);
      dev_irq = 32'h0008_0003; tick();
      chk("R3 shared raw bits alone", irq_src, 32'h0);
      dev_irq = '0; tick();
   endtask

   task automatic t_latency();
      dev_irq[5] = 1'b1; #1;
      chk("R4 no change before edge", irq_src, 32'h0);
      tick();
      chk("R4 change after edge", irq_src, 32'h0000_0020);
      dev_irq = '0; tick();
   endtask

   task automatic t_set_clear();
      reg_write(2'd0, 32'h0000_0010);
      exp_en = exp_en | (32'h10 & GATE);
      chk("R5 set one bit", clk_en, exp_en);
      reg_write(2'd0, 32'hFFFF_FFFF);
      exp_en = exp_en | GATE;
      chk("R5 set all", clk_en, exp_en);
      chk("R10 pin ids stay off", clk_en & 32'hC000_0001, 32'h0);
      chk("R11 timers on", {29'd0, tmr_clk_en}, 32'h7);
      reg_write(2'd1, 32'h0008_0000);
      exp_en = exp_en & ~32'h0008_0000;
      chk("R6 clear timer bit", clk_en, exp_en);
      chk("R11 timers stop together", {29'd0, tmr_clk_en}, 32'h0);
      reg_write(2'd1, 32'hFFFF_FFFF);
      exp_en = ON;
      chk("R9 system clock stays on", clk_en, exp_en);
   endtask

   task automatic t_reg_sel();
      reg_write(2'd0, 32'h0000_0300);
      exp_en = exp_en | 32'h300;
      reg_sel = 2'd0; #1; chk("R7 set view reads zero", reg_rdata, 32'h0);
      reg_sel = 2'd1; #1; chk("R7 clear view reads zero", reg_rdata, 32'h0);
      reg_sel = 2'd3; #1; chk("R7 sel 3 reads zero", reg_rdata, 32'h0);
      reg_sel = 2'd2; #1; chk("R7 status read", reg_rdata, exp_en);
      reg_write(2'd2, 32'hFFFF_FFFF);
      chk("R7 write to status ignored", clk_en, exp_en);
      reg_write(2'd3, 32'hFFFF_FFFF);
      chk("R7 write to sel 3 ignored", clk_en, exp_en);
   endtask

   task automatic t_forward_gated();
      reg_write(2'd1, 32'hFFFF_FFFF);
      exp_en = ON;
      dev_irq[7] = 1'b1; tmr_irq = 3'b100; tick();
      chk("R12 gated ids still forward", irq_src, 32'h0008_0080);
      dev_irq = '0; tmr_irq = '0; tick();
   endtask

   initial begin
      repeat (3) @(posedge clk);
      #1;
      t_reset();
      rst_n = 1'b1;
      tick();
      t_sys_merge();
      t_tmr_merge();
      t_ext_route();
      t_latency();
      t_set_clear();
      t_reg_sel();
      t_forward_gated();
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      checks++;
      failures++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule